// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block derives two nested timing marks from one synthesized source clock. It produces a frame mark once every `DIV` source cycles and a multiframe mark once every `MF_FRAMES` frames. With a 155.52 MHz source and `DIV = 19440`, these are the 8 kHz and 2 kHz sync signals. Each output has its own two settings. One selects between a 50% duty clock and a pulse one source cycle wide. The other inverts the output. Both outputs are registered on the source clock, so every transition lands on a source clock edge.

An external sync input can discipline the phase of the generator. When discipline is enabled, each rising edge of that input is synchronized into the source domain and reloads the counters. A rate select decides how far the reload reaches. At frame rate only the frame counter is cleared and the multiframe position is kept. At multiframe rate both counters are cleared.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst` is high, both counters are held at zero. With both invert bits and both pulse bits low, `fs_out` and `mfs_out` read 1 after a reset edge.
- R2: In clock mode (`fs_pulse`=0, `fs_inv`=0), the frame phase counts 0..DIV-1 and wraps to 0. `fs_out` is 1 for phases 0..DIV/2-1 and 0 for the remaining phases, which gives a period of DIV cycles.
- R3: In clock mode (`mfs_pulse`=0, `mfs_inv`=0), `mfs_out` is 1 during multiframe positions 0..MF_FRAMES/2-1 and 0 during the remaining positions, which gives a period of MF_FRAMES*DIV cycles.
- R4: With `fs_pulse`=1, `fs_out` is active for exactly one source cycle, at frame phase 0.
- R5: With `mfs_pulse`=1, `mfs_out` is active for one source cycle, at frame phase 0 of multiframe position 0. This cycle always coincides with a frame mark.
- R6: `fs_inv`=1 inverts `fs_out` and `mfs_inv`=1 inverts `mfs_out`. Each bit affects only its own output, in either mode.
- R7: The multiframe position advances by one, modulo MF_FRAMES, only when the frame phase wraps from DIV-1 to 0. It is otherwise unchanged.
- R8: With `sync_en`=1 and `sync_rate`=0 (frame rate), suppose the first source edge that samples `sync_in` high after it was low is edge k. Then the frame phase is 0 after edge k+SYNC_STAGES. The multiframe position is not changed, even when this reload falls on a frame wrap.
- R9: With `sync_en`=1 and `sync_rate`=1 (multiframe rate), the same sync edge clears both the frame phase and the multiframe position at edge k+SYNC_STAGES.
- R10: A `sync_in` rising edge has no effect while `sync_en`=0. A `sync_in` held high causes no reload after its first one.
- R11: The outputs change only at source clock edges. A change of an invert or pulse bit between edges leaves both outputs unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesized source clock |
| rst | input | 1 | Synchronous reset, active high |
| fs_inv | input | 1 | Invert the frame sync output |
| fs_pulse | input | 1 | Frame sync output as a one-cycle pulse (1) or a 50% clock (0) |
| mfs_inv | input | 1 | Invert the multiframe sync output |
| mfs_pulse | input | 1 | Multiframe sync output as a one-cycle pulse (1) or a 50% clock (0) |
| sync_en | input | 1 | Enable discipline by the external sync input |
| sync_rate | input | 1 | External sync rate: 0 is frame rate, 1 is multiframe rate |
| sync_in | input | 1 | External sync, asynchronous to clk |
| fs_out | output | 1 | Frame sync output |
| mfs_out | output | 1 | Multiframe sync output |

## Verification
The hardest case to reach from the ports is a frame-rate sync reload that lands on the same edge as a frame wrap. In that cycle the reload must win, and the multiframe position must not advance. The bench keeps its own phase model. It raises `sync_in` on the cycle in which the model's frame phase equals DIV-1-SYNC_STAGES, so the synchronizer delay carries the reload exactly onto the wrap edge. A second sync edge is applied with discipline disabled, and a third is held high, to show that neither moves the phase.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic {
        SYNC_AT_FRAME  = 1'b0,
        SYNC_AT_MFRAME = 1'b1
    } sync_rate_e;

    typedef struct packed {
        logic invert;
        logic pulse;
    } wave_cfg_t;

    // Output level for one position: the clock level in clock mode, the
    // start-of-period mark in pulse mode, then the optional inversion.
    function automatic logic wave_level(logic first_half, logic at_start, wave_cfg_t cfg);
        return (cfg.pulse ? at_start : first_half) ^ cfg.invert;
    endfunction

endpackage

// File: rtl/fsg_sync_detect.sv
module fsg_sync_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
    parameter int DIV = 19440,
    localparam int FW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reload,
    output logic [FW-1:0] cnt_q,
    output logic [FW-1:0] cnt_d,
    output logic          wrap
);
    localparam logic [FW-1:0] LAST = FW'(DIV - 1);

    always_comb begin
        wrap = !reload && (cnt_q == LAST);
        if (reload || cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + FW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fsg_mframe_ctr.sv
module fsg_mframe_ctr #(
    parameter int MF_FRAMES = 4,
    localparam int MW = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          reload,
    output logic [MW-1:0] cnt_q,
    output logic [MW-1:0] cnt_d
);
    localparam logic [MW-1:0] LAST = MW'(MF_FRAMES - 1);

    always_comb begin
        if (reload)
            cnt_d = '0;
        else if (advance)
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + MW'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fsg_shaper.sv
module fsg_shaper
    import fsg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wave_cfg_t cfg,
    input  logic      first_half_d,
    input  logic      at_start_d,
    output logic      level_q
);
    always_ff @(posedge clk) begin
        if (rst) level_q <= wave_level(1'b1, 1'b1, cfg);
        else     level_q <= wave_level(first_half_d, at_start_d, cfg);
    end
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int DIV         = 19440,
    parameter int MF_FRAMES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fs_inv,
    input  logic fs_pulse,
    input  logic mfs_inv,
    input  logic mfs_pulse,
    input  logic sync_en,
    input  logic sync_rate,
    input  logic sync_in,
    output logic fs_out,
    output logic mfs_out
);
    localparam int FW = $clog2(DIV);
    localparam int MW = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;
    localparam logic [FW-1:0] F_HALF = FW'(DIV / 2);
    localparam logic [MW-1:0] M_HALF = MW'(MF_FRAMES / 2);
    localparam int N_OUT = 2;

    logic          sync_rise;
    logic          ld_frame, ld_mf;
    logic [FW-1:0] fcnt_q, fcnt_d;
    logic [MW-1:0] mcnt_q, mcnt_d;
    logic          frame_wrap;
    sync_rate_e    rate;

    wave_cfg_t     cfg      [N_OUT];
    logic          half_d   [N_OUT];
    logic          start_d  [N_OUT];
    logic          level_q  [N_OUT];

    fsg_sync_detect #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .din(sync_in), .rise(sync_rise)
    );

    assign rate     = sync_rate_e'(sync_rate);
    assign ld_frame = sync_rise && sync_en;
    assign ld_mf    = ld_frame && (rate == SYNC_AT_MFRAME);

    fsg_frame_ctr #(.DIV(DIV)) frame_i (
        .clk(clk), .rst(rst), .reload(ld_frame),
        .cnt_q(fcnt_q), .cnt_d(fcnt_d), .wrap(frame_wrap)
    );

    fsg_mframe_ctr #(.MF_FRAMES(MF_FRAMES)) mframe_i (
        .clk(clk), .rst(rst), .advance(frame_wrap), .reload(ld_mf),
        .cnt_q(mcnt_q), .cnt_d(mcnt_d)
    );

    // Index 0: frame output, index 1: multiframe output.
    always_comb begin
        cfg[0]     = '{invert: fs_inv,  pulse: fs_pulse};
        cfg[1]     = '{invert: mfs_inv, pulse: mfs_pulse};
        half_d[0]  = fcnt_d < F_HALF;
        start_d[0] = fcnt_d == '0;
        half_d[1]  = mcnt_d < M_HALF;
        start_d[1] = (mcnt_d == '0) && (fcnt_d == '0);
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        fsg_shaper shp_i (
            .clk(clk), .rst(rst), .cfg(cfg[g]),
            .first_half_d(half_d[g]), .at_start_d(start_d[g]),
            .level_q(level_q[g])
        );
    end

    assign fs_out  = level_q[0];
    assign mfs_out = level_q[1];
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
    parameter int DIV       = 19440,
    parameter int MF_FRAMES = 4,
    localparam int FW = $clog2(DIV),
    localparam int MW = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic [FW-1:0] fcnt,
    input logic [MW-1:0] mcnt,
    input logic          ld_frame,
    input logic          ld_mf,
    input logic          fs_out,
    input logic          mfs_out,
    input logic          fs_inv,
    input logic          fs_pulse,
    input logic          mfs_inv,
    input logic          mfs_pulse
);
    localparam logic [FW-1:0] F_LAST = FW'(DIV - 1);

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld_frame && fcnt != F_LAST) |=> fcnt == $past(fcnt) + FW'(1)); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!ld_frame && fcnt == F_LAST) |=> fcnt == '0); // R2
    AST_MF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld_mf && fcnt != F_LAST) |=> $stable(mcnt)); // R7
    AST_RELOAD_FRAME: assert property (@(posedge clk) disable iff (rst)
        ld_frame |=> fcnt == '0); // R8
    AST_FRAME_SYNC_KEEPS_MF: assert property (@(posedge clk) disable iff (rst)
        (ld_frame && !ld_mf) |=> $stable(mcnt)); // R8
    AST_RELOAD_MF: assert property (@(posedge clk) disable iff (rst)
        ld_mf |=> mcnt == '0); // R9
    AST_FS_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        (fs_pulse && !fs_inv && fcnt == '0 && !ld_frame) |=> !fs_out); // R4
    AST_MF_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        (mfs_pulse && fs_pulse && !mfs_inv && !fs_inv) |=> (!mfs_out || fs_out)); // R5
endmodule

bind frame_sync_gen fsg_checker #(.DIV(DIV), .MF_FRAMES(MF_FRAMES)) chk_i (
    .clk(clk), .rst(rst), .fcnt(fcnt_q), .mcnt(mcnt_q),
    .ld_frame(ld_frame), .ld_mf(ld_mf),
    .fs_out(fs_out), .mfs_out(mfs_out),
    .fs_inv(fs_inv), .fs_pulse(fs_pulse),
    .mfs_inv(mfs_inv), .mfs_pulse(mfs_pulse)
);

// File: tb/frame_sync_gen_tb_top.sv
`timescale 1ns/1ps
module frame_sync_gen_tb_top;
    localparam int DIV = 10;
    localparam int MFF = 4;
    localparam int STG = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fs_inv = 0, fs_pulse = 0, mfs_inv = 0, mfs_pulse = 0;
    logic sync_en = 0, sync_rate = 0, sync_in = 0;
    logic fs_out, mfs_out;

    int checks = 0;
    int errors = 0;
    int edge_no = 0;
    int reload_edge = -1;
    int pf = 0, pm = 0;
    logic exp_fs = 1'b1, exp_mfs = 1'b1;
    bit done = 0;

    always #10 clk = ~clk;

    frame_sync_gen #(.DIV(DIV), .MF_FRAMES(MFF), .SYNC_STAGES(STG)) dut_i (
        .clk(clk), .rst(rst), .fs_inv(fs_inv), .fs_pulse(fs_pulse),
        .mfs_inv(mfs_inv), .mfs_pulse(mfs_pulse), .sync_en(sync_en),
        .sync_rate(sync_rate), .sync_in(sync_in),
        .fs_out(fs_out), .mfs_out(mfs_out)
    );

    // Phase model written from the requirements.
    always @(posedge clk) begin
        edge_no = edge_no + 1;
        if (rst) begin
            pf = 0; pm = 0;
        end else if (edge_no == reload_edge && sync_en) begin
            pf = 0;
            if (sync_rate) pm = 0;
        end else if (pf == DIV - 1) begin
            pf = 0; pm = (pm + 1) % MFF;
        end else begin
            pf = pf + 1;
        end
        exp_fs  = (fs_pulse  ? (pf == 0)            : (pf < DIV / 2)) ^ fs_inv;
        exp_mfs = (mfs_pulse ? (pf == 0 && pm == 0) : (pm < MFF / 2)) ^ mfs_inv;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, edge_no);
        end
    endtask

    task automatic compare(input string tag);
        check(fs_out == exp_fs, {tag, " fs_out"}, fs_out, exp_fs);
        check(mfs_out == exp_mfs, {tag, " mfs_out"}, mfs_out, exp_mfs);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare(tag);
        end
    endtask

    task automatic set_cfg(input logic fi, input logic fp, input logic mi, input logic mp);
        @(negedge clk);
        fs_inv = fi; fs_pulse = fp; mfs_inv = mi; mfs_pulse = mp;
    endtask

    task automatic raise_sync;
        sync_in = 1'b1;
        reload_edge = edge_no + 1 + STG;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        run(3, "R1 reset");
        check(fs_out == 1'b1 && mfs_out == 1'b1, "R1 reset levels", {fs_out, mfs_out}, 3);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_clock;
        int hi = 0;
        set_cfg(0, 0, 0, 0);
        run(3 * MFF * DIV, "R2 R3 R7 clock mode");
        for (int i = 0; i < DIV; i++) begin
            @(negedge clk); compare("R2 duty");
            hi += fs_out;
        end
        check(hi == DIV / 2, "R2 high count per frame", hi, DIV / 2);
    endtask

    task automatic t_pulse;
        int fsn = 0, mfn = 0;
        set_cfg(0, 1, 0, 1);
        for (int i = 0; i < 2 * MFF * DIV; i++) begin
            @(negedge clk); compare("R4 R5 pulse mode");
            if (i > 0) begin
                fsn += fs_out; mfn += mfs_out;
                if (mfs_out) check(fs_out, "R5 coincidence", fs_out, 1);
            end
        end
        check(fsn >= 2 * MFF - 1 && fsn <= 2 * MFF, "R4 pulse count", fsn, 2 * MFF);
        check(mfn >= 1 && mfn <= 2, "R5 pulse count", mfn, 2);
    endtask

    task automatic t_invert;
        set_cfg(1, 0, 0, 1);
        run(MFF * DIV, "R6 fs inverted");
        set_cfg(0, 1, 1, 0);
        run(MFF * DIV, "R6 mfs inverted");
        set_cfg(1, 1, 1, 1);
        run(MFF * DIV, "R6 both inverted");
    endtask

    task automatic t_cfg_timing;
        logic f0, m0;
        set_cfg(0, 0, 0, 0);
        @(negedge clk);
        f0 = fs_out; m0 = mfs_out;
        fs_inv = 1'b1; mfs_inv = 1'b1;
        #2;
        check(fs_out == f0, "R11 fs between edges", fs_out, f0);
        check(mfs_out == m0, "R11 mfs between edges", mfs_out, m0);
        run(DIV, "R11 after edge");
        set_cfg(0, 0, 0, 0);
    endtask

    task automatic t_sync(input logic rate, input int phase, input string tag);
        set_cfg(0, 1, 0, 1);
        sync_en = 1'b1; sync_rate = rate;
        do begin
            @(negedge clk); compare(tag);
        end while (pf != phase);
        raise_sync();
        run(2 * MFF * DIV, tag);
        sync_in = 1'b0;
        run(4, tag);
    endtask

    task automatic t_sync_ignored;
        sync_en = 1'b0; sync_rate = 1'b1;
        @(negedge clk);
        raise_sync();
        run(MFF * DIV, "R10 disabled");
        sync_in = 1'b0;
        run(3, "R10 disabled");
        sync_en = 1'b1;
        run(2, "R10 enable");
    endtask

    initial begin
        t_reset();
        t_clock();
        t_pulse();
        t_invert();
        t_cfg_timing();
        t_sync(1'b0, 3, "R8 frame sync mid frame");
        t_sync(1'b0, DIV - 1 - STG, "R8 frame sync on wrap");
        t_sync(1'b1, 5, "R9 multiframe sync");
        t_sync_ignored();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule